// File: doc/BRIEF.md
# Interrupt Request Aggregator

This block collects up to fourteen peripheral interrupt request lines and merges them into one interrupt output for a processor. Each line can be set to one of two sensing modes. In level mode the line is pending while its input is at the chosen active level. In edge mode a transition in the chosen direction marks the line pending, and it stays pending until software clears it. Each line also has its own polarity bit and its own disable bit.

Software reaches the block through four 32-bit words on a simple word-addressed register port. The words, by address, are:

- 0: mode select
- 1: polarity select
- 2: disable mask
- 3: pending status

Reading word 3 shows which lines are pending. Writing ones to word 3 clears the matching edge-captured bits.

Request inputs are asynchronous. Each one passes through a two-stage synchroniser before any level or edge check. The output is registered once after the pending and mask logic.

Top module: `irq_collector`

## Requirements
- R1: While reset is asserted and in the first cycle after it, every register reads zero and irqOut is 0.
- R2: Words 0, 1 and 2 read back the low 14 bits last written to them. Bits 31..14 read as zero.
- R3: A line in level mode (word 0 bit = 0) with polarity bit 1 is pending while its input is high. It stops being pending once its input is low.
- R4: A line in level mode with polarity bit 0 is pending while its input is low. This is the state after reset, so with all inputs low every line becomes pending.
- R5: Writing a one to a word 3 bit of a level-mode line whose input is still active leaves that bit set.
- R6: A line in edge mode (word 0 bit = 1) with polarity 1 becomes pending on a rising input. It stays pending after the input falls, until a one is written to its bit in word 3.
- R7: A line in edge mode with polarity 0 becomes pending on a falling input only. A rising input leaves it clear.
- R8: If a new edge and a clearing write to the same line are applied at the same clock edge, the line stays pending.
- R9: A line whose word 2 bit is 1 still shows in word 3 but cannot raise irqOut. Clearing that mask bit lets it do so again.
- R10: irqOut is the OR over all lines of (pending AND NOT disabled), delayed by one register stage.
- R11: A change on a request input reaches word 3 at the third rising clock edge after the change. It reaches irqOut at the fourth.
- R12: Line x is controlled by bit x of every word. Lines act independently, so several lines can be pending at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regAddr | input | 2 | Word address of the register access |
| regWrEn | input | 1 | Write strobe for the addressed word |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data of the addressed word, combinational |
| irqIn | input | 14 | Asynchronous interrupt request lines |
| irqOut | output | 1 | Combined interrupt to the processor |

## Verification
A wrong pending bit appears on the status word in the cycle after the wrong update. If the bit is not masked, it also appears on irqOut one cycle after that. A synchroniser that is too short or too long moves the first appearance of a request by exactly one edge, so the bench samples the status word and the output edge by edge around a single input change. An edge-mode bit that was lost, or a clear that was wrongly honoured, stays wrong until the next edge or write. The bench checks for this after the input has returned to idle, and again at the exact cycle where an edge and a clear collide.

// File: rtl/irq_collector_pkg.sv
package irq_collector_pkg;
  localparam int REG_ADDR_W = 2;
  localparam logic [REG_ADDR_W-1:0] ADDR_MODE = 2'd0;
  localparam logic [REG_ADDR_W-1:0] ADDR_POL  = 2'd1;
  localparam logic [REG_ADDR_W-1:0] ADDR_MASK = 2'd2;
  localparam logic [REG_ADDR_W-1:0] ADDR_PEND = 2'd3;

  // strobes from register decode to datapath
  typedef struct packed {
    logic wrMode;
    logic wrPol;
    logic wrMask;
    logic clrPend;
  } regStrobe_t;
endpackage

// File: rtl/irq_collector_ctrl.sv
module irq_collector_ctrl
  import irq_collector_pkg::*;
#(
  parameter int NUM_LINES = 14,
  parameter int DATA_W    = 32
) (
  input  logic [REG_ADDR_W-1:0] regAddr,
  input  logic                  regWrEn,
  input  logic [DATA_W-1:0]     regWrData,
  input  logic [NUM_LINES-1:0]  modeCfg,
  input  logic [NUM_LINES-1:0]  polCfg,
  input  logic [NUM_LINES-1:0]  maskCfg,
  input  logic [NUM_LINES-1:0]  pendVec,
  output regStrobe_t            stb,
  output logic [NUM_LINES-1:0]  wrBits,
  output logic [DATA_W-1:0]     regRdData
);
  logic unusedHiBits;
  assign unusedHiBits = ^regWrData[DATA_W-1:NUM_LINES];

  assign wrBits = regWrData[NUM_LINES-1:0];

  always_comb begin
    stb.wrMode  = regWrEn && (regAddr == ADDR_MODE);
    stb.wrPol   = regWrEn && (regAddr == ADDR_POL);
    stb.wrMask  = regWrEn && (regAddr == ADDR_MASK);
    stb.clrPend = regWrEn && (regAddr == ADDR_PEND);
  end

  always_comb begin
    regRdData = '0;
    unique case (regAddr)
      ADDR_MODE: regRdData[NUM_LINES-1:0] = modeCfg;
      ADDR_POL:  regRdData[NUM_LINES-1:0] = polCfg;
      ADDR_MASK: regRdData[NUM_LINES-1:0] = maskCfg;
      default:   regRdData[NUM_LINES-1:0] = pendVec;
    endcase
  end
endmodule

// File: rtl/irq_collector_dp.sv
module irq_collector_dp
  import irq_collector_pkg::*;
#(
  parameter int NUM_LINES   = 14,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_LINES-1:0] irqIn,
  input  regStrobe_t           stb,
  input  logic [NUM_LINES-1:0] wrBits,
  output logic [NUM_LINES-1:0] modeCfg,
  output logic [NUM_LINES-1:0] polCfg,
  output logic [NUM_LINES-1:0] maskCfg,
  output logic [NUM_LINES-1:0] pendVec,
  output logic                 irqOut
);
  logic [NUM_LINES-1:0] syncChain [SYNC_STAGES];
  logic [NUM_LINES-1:0] syncd;
  logic [NUM_LINES-1:0] prevSyncd;
  logic [NUM_LINES-1:0] pendNext;

  // configuration words
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeCfg <= '0;
      polCfg  <= '0;
      maskCfg <= '0;
    end else begin
      if (stb.wrMode) modeCfg <= wrBits;
      if (stb.wrPol)  polCfg  <= wrBits;
      if (stb.wrMask) maskCfg <= wrBits;
    end
  end

  // input synchroniser
  generate
    for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncChain[s] <= '0;
        else if (s == 0) syncChain[s] <= irqIn;
        else syncChain[s] <= syncChain[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign syncd = syncChain[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevSyncd <= '0;
    else prevSyncd <= syncd;
  end

  // per-line pending update
  generate
    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
      logic levelHit;
      logic edgeHit;
      logic clrHit;
      assign levelHit = polCfg[i] ? syncd[i] : ~syncd[i];
      assign edgeHit  = polCfg[i] ? (syncd[i] & ~prevSyncd[i])
                                  : (~syncd[i] & prevSyncd[i]);
      assign clrHit   = stb.clrPend & wrBits[i];
      assign pendNext[i] = modeCfg[i] ? (edgeHit | (pendVec[i] & ~clrHit))
                                      : levelHit;
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendVec <= '0;
      irqOut  <= 1'b0;
    end else begin
      pendVec <= pendNext;
      irqOut  <= |(pendVec & ~maskCfg);
    end
  end
endmodule

// File: rtl/irq_collector.sv
module irq_collector
  import irq_collector_pkg::*;
#(
  parameter int NUM_LINES   = 14,
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [REG_ADDR_W-1:0] regAddr,
  input  logic                  regWrEn,
  input  logic [DATA_W-1:0]     regWrData,
  output logic [DATA_W-1:0]     regRdData,
  input  logic [NUM_LINES-1:0]  irqIn,
  output logic                  irqOut
);
  regStrobe_t           stb;
  logic [NUM_LINES-1:0] wrBits;
  logic [NUM_LINES-1:0] modeCfg;
  logic [NUM_LINES-1:0] polCfg;
  logic [NUM_LINES-1:0] maskCfg;
  logic [NUM_LINES-1:0] pendVec;

  irq_collector_ctrl #(.NUM_LINES(NUM_LINES), .DATA_W(DATA_W)) u_ctrl (
    .regAddr(regAddr), .regWrEn(regWrEn), .regWrData(regWrData),
    .modeCfg(modeCfg), .polCfg(polCfg), .maskCfg(maskCfg), .pendVec(pendVec),
    .stb(stb), .wrBits(wrBits), .regRdData(regRdData)
  );

  irq_collector_dp #(.NUM_LINES(NUM_LINES), .SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk(clk), .rstN(rstN), .irqIn(irqIn), .stb(stb), .wrBits(wrBits),
    .modeCfg(modeCfg), .polCfg(polCfg), .maskCfg(maskCfg), .pendVec(pendVec),
    .irqOut(irqOut)
  );
endmodule

// File: rtl/irq_collector_chk.sv
module irq_collector_chk
  import irq_collector_pkg::*;
#(
  parameter int NUM_LINES = 14,
  parameter int DATA_W    = 32
) (
  input logic                  clk,
  input logic                  rstN,
  input logic [REG_ADDR_W-1:0] regAddr,
  input logic                  regWrEn,
  input logic [DATA_W-1:0]     regWrData,
  input logic [NUM_LINES-1:0]  modeCfg,
  input logic [NUM_LINES-1:0]  polCfg,
  input logic [NUM_LINES-1:0]  maskCfg,
  input logic [NUM_LINES-1:0]  pendVec,
  input logic                  irqOut
);
  p_reset_clear_r1: assert property (@(posedge clk) disable iff (!rstN)
    $past(!rstN) |-> (modeCfg == '0 && polCfg == '0 && maskCfg == '0 &&
                      pendVec == '0 && !irqOut));

  p_out_high_r10: assert property (@(posedge clk) disable iff (!rstN)
    (|(pendVec & ~maskCfg)) |=> irqOut);

  p_out_low_r10: assert property (@(posedge clk) disable iff (!rstN)
    !(|(pendVec & ~maskCfg)) |=> !irqOut);

  p_edge_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    !(regWrEn && regAddr == ADDR_PEND) |=>
      ((pendVec & $past(modeCfg & pendVec)) == $past(modeCfg & pendVec)));

  p_mask_write_r9: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == ADDR_MASK) |=> maskCfg == $past(regWrData[NUM_LINES-1:0]));
endmodule

bind irq_collector irq_collector_chk #(.NUM_LINES(NUM_LINES), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
  .regWrData(regWrData), .modeCfg(modeCfg), .polCfg(polCfg),
  .maskCfg(maskCfg), .pendVec(pendVec), .irqOut(irqOut)
);

// File: tb/irq_collector_test.sv
module irq_collector_test;
  localparam int CLK_PERIOD = 10;
  localparam int NL = 14;
  localparam logic [31:0] ALL = 32'h3FFF;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  regAddr = '0;
  logic        regWrEn = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic [NL-1:0] irqIn = '0;
  logic        irqOut;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_collector uut (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .irqIn(irqIn), .irqOut(irqOut)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic writeReg(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic readReg(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdData;
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic checkReg(input string tag, input logic [1:0] a, input logic [31:0] exp);
    logic [31:0] v;
    readReg(a, v);
    check(tag, v, exp);
  endtask

  task automatic baseline();
    writeReg(2'd0, 32'h0);
    writeReg(2'd1, ALL);
    writeReg(2'd2, 32'h0);
    irqIn = '0;
    waitCyc(6);
  endtask

  task automatic t_reset();
    waitCyc(2);
    check("R1 irqOut in reset", {31'b0, irqOut}, 32'h0);
    for (int a = 0; a < 4; a++) checkReg("R1 reg in reset", a[1:0], 32'h0);
    rstN = 1'b1;
    waitCyc(6);
    checkReg("R4 default low-active pending", 2'd3, ALL);
    check("R4 default irqOut", {31'b0, irqOut}, 32'h1);
  endtask

  task automatic t_readback();
    writeReg(2'd2, 32'hFFFF_FFFF);
    checkReg("R2 mask readback upper zero", 2'd2, ALL);
    writeReg(2'd0, 32'hABCD_1234);
    checkReg("R2 mode readback", 2'd0, 32'h1234);
    writeReg(2'd1, 32'h0000_2A5A);
    checkReg("R2 pol readback", 2'd1, 32'h2A5A);
    baseline();
    checkReg("R3 baseline no pending", 2'd3, 32'h0);
    check("R10 baseline irqOut low", {31'b0, irqOut}, 32'h0);
  endtask

  task automatic t_level_high();
    @(negedge clk);
    irqIn[3] = 1'b1;
    @(negedge clk); #1 check("R11 pending after 1 edge", regRdData, 32'h0);
    @(negedge clk); #1 check("R11 pending after 2 edges", regRdData, 32'h0);
    @(negedge clk); #1 check("R11 pending after 3 edges", regRdData, 32'h8);
    check("R10 irqOut lags pending", {31'b0, irqOut}, 32'h0);
    @(negedge clk); #1 check("R10 irqOut after 4 edges", {31'b0, irqOut}, 32'h1);
    writeReg(2'd3, 32'h8);
    waitCyc(2);
    checkReg("R5 level clear no effect", 2'd3, 32'h8);
    irqIn[3] = 1'b0;
    waitCyc(5);
    checkReg("R3 level drops", 2'd3, 32'h0);
    check("R3 irqOut drops", {31'b0, irqOut}, 32'h0);
  endtask

  task automatic t_level_low();
    writeReg(2'd1, 32'h3FDF);
    waitCyc(2);
    checkReg("R4 low-active pending", 2'd3, 32'h20);
    irqIn[5] = 1'b1;
    waitCyc(5);
    checkReg("R4 high input clears", 2'd3, 32'h0);
    writeReg(2'd1, ALL);
    irqIn[5] = 1'b0;
    waitCyc(5);
  endtask

  task automatic t_edge_rise();
    writeReg(2'd0, 32'h1);
    irqIn[0] = 1'b1;
    waitCyc(5);
    checkReg("R6 rising captured", 2'd3, 32'h1);
    irqIn[0] = 1'b0;
    waitCyc(5);
    checkReg("R6 held after input low", 2'd3, 32'h1);
    writeReg(2'd3, 32'h1);
    checkReg("R6 cleared by write", 2'd3, 32'h0);
    check("R6 irqOut low after clear", {31'b0, irqOut}, 32'h0);
  endtask

  task automatic t_edge_fall();
    writeReg(2'd0, 32'h2000);
    writeReg(2'd1, 32'h1FFF);
    irqIn[13] = 1'b1;
    waitCyc(5);
    checkReg("R7 rising ignored", 2'd3, 32'h0);
    irqIn[13] = 1'b0;
    waitCyc(5);
    checkReg("R7 falling captured", 2'd3, 32'h2000);
    writeReg(2'd3, 32'h2000);
    writeReg(2'd1, ALL);
    writeReg(2'd0, 32'h0);
    waitCyc(3);
    checkReg("R7 cleared", 2'd3, 32'h0);
  endtask

  task automatic t_collide();
    writeReg(2'd0, 32'h80);
    irqIn[7] = 1'b1;
    waitCyc(5);
    irqIn[7] = 1'b0;
    waitCyc(5);
    checkReg("R8 first edge", 2'd3, 32'h80);
    @(negedge clk);
    irqIn[7] = 1'b1;
    repeat (2) @(negedge clk);
    regAddr = 2'd3; regWrData = 32'h80; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
    waitCyc(2);
    checkReg("R8 edge wins over clear", 2'd3, 32'h80);
    writeReg(2'd3, 32'h80);
    checkReg("R8 later clear works", 2'd3, 32'h0);
    irqIn[7] = 1'b0;
    writeReg(2'd0, 32'h0);
    waitCyc(4);
  endtask

  task automatic t_mask();
    writeReg(2'd2, 32'h8);
    irqIn[3] = 1'b1;
    waitCyc(6);
    checkReg("R9 masked still pending", 2'd3, 32'h8);
    check("R9 masked irqOut low", {31'b0, irqOut}, 32'h0);
    writeReg(2'd2, 32'h0);
    waitCyc(1);
    check("R9 unmask raises irqOut", {31'b0, irqOut}, 32'h1);
    irqIn[3] = 1'b0;
    irqIn[2] = 1'b1;
    irqIn[9] = 1'b1;
    waitCyc(6);
    checkReg("R12 two lines pending", 2'd3, 32'h204);
    writeReg(2'd2, 32'h004);
    waitCyc(1);
    check("R12 other line keeps irqOut", {31'b0, irqOut}, 32'h1);
    writeReg(2'd2, 32'h204);
    waitCyc(1);
    check("R12 all masked irqOut low", {31'b0, irqOut}, 32'h0);
    irqIn = '0;
    writeReg(2'd2, 32'h0);
    waitCyc(5);
  endtask

  initial begin
    t_reset();
    t_readback();
    t_level_high();
    t_level_low();
    t_edge_rise();
    t_edge_fall();
    t_collide();
    t_mask();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule